// File: doc/BRIEF.md
# Single-Wire Line Power-State Controller

This block decides when a device attached to a single-wire serial line leaves its low-power state and when it returns to it. The raw line passes through a two-flop synchronizer and then a debounce filter. The filter's rejection width depends on the power state: it is wide while asleep and narrow while awake. A long enough low level on the filtered line while asleep counts as a wake request. The controller then enters a hold phase, during which the host must keep the line high for a fixed interval before traffic may start. After that interval it enters I/O mode.

A watchdog starts at the moment of wake and runs through both awake states. When it expires, the block returns to sleep, no matter what the line is doing. While the block is asleep, the watchdog is held at zero. Every threshold is given in nanoseconds and converted to clock cycles from a clock-frequency parameter. The block outputs its state, the filtered line level and a one-cycle wake strobe. Bit coding and command handling live downstream.

Top module: `swpw_top`

## Requirements
- R1: After reset the state is sleep (`state_o` = 2'b00), `line_filt_o` is 1 and `wake_stb_o` is 0.
- R2: In sleep, a low pulse on `line_i` shorter than SLP cycles leaves `line_filt_o` at 1. A low pulse of W ≥ SLP cycles makes `line_filt_o` low for exactly W cycles. SLP = ceil(SLEEP_GLITCH_NS·CLK_HZ/1e9).
- R3: In the hold and I/O states, a low or high pulse shorter than ACT cycles leaves `line_filt_o` unchanged. A pulse of W ≥ ACT cycles appears on `line_filt_o` for exactly W cycles. ACT is derived from ACT_GLITCH_NS in the same way.
- R4: In sleep, the block wakes only when `line_filt_o` stays low for at least WAKE consecutive cycles (derived from WAKE_LOW_NS). A high glitch shorter than SLP inside the low period does not break the run.
- R5: `wake_stb_o` is high for exactly one cycle, in the first cycle of the hold state (`state_o` = 2'b01), and only on a transition out of sleep.
- R6: I/O mode (`state_o` = 2'b10) begins exactly READY cycles after the last rise of `line_filt_o` in the hold state. Any accepted low level restarts that interval.
- R7: The block returns to sleep exactly WDOG cycles after the wake strobe, whatever the line does, from either awake state.
- R8: In I/O mode, data-length low pulses and low periods longer than WAKE cycles neither change the state nor raise `wake_stb_o`.
- R9: `state_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw serial line level, idles high |
| state_o | output | 2 | 00 sleep, 01 hold before traffic, 10 I/O |
| line_filt_o | output | 1 | Synchronized and debounced line level |
| wake_stb_o | output | 1 | One-cycle pulse on leaving sleep |

## Verification
The bench uses a scaled configuration and sweeps low-pulse widths across both filter thresholds. Pulses one cycle under a threshold must leave the filtered output untouched, and pulses at or over it must reproduce their width exactly. A second sweep around the wake length separates waking from not waking to a single cycle. A split low pulse is tried with a short and with a long high gap, which shows whether the wake run is judged on the filtered level or the raw one. Ready and watchdog intervals are timed exactly from port events: once with a clean line, once with a low glitch and with a restarting low, and once with the line stuck low. I/O mode is then flooded with data pulses and an over-long low to confirm that nothing but the watchdog moves the state.

// File: rtl/swpw_pkg.sv
package swpw_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_HOLD  = 2'b01,
    ST_IO    = 2'b10
  } pw_state_e;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                               longint unsigned dur_ns);
    longint unsigned c;
    c = (dur_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // Bits needed to hold the values 0 .. limit-1.
  function automatic int unsigned cnt_bits(int unsigned limit);
    if (limit < 3) return 1;
    return $clog2(limit);
  endfunction

endpackage

// File: rtl/swpw_sync.sv
module swpw_sync #(
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {2{IDLE_LEVEL}};
    else        stage_q <= {stage_q[0], async_i};
  end

  assign sync_o = stage_q[1];

endmodule

// File: rtl/swpw_glitch.sv
module swpw_glitch #(
  parameter int unsigned ACT_CYC = 5,
  parameter int unsigned SLP_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic mode_act_i,
  output logic filt_o,
  output logic flip_o
);

  localparam int unsigned CW = swpw_pkg::cnt_bits(SLP_CYC);
  localparam logic [CW-1:0] ACT_M1 = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] SLP_M1 = CW'(SLP_CYC - 1);

  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr_m1;
  logic          differ;
  logic          at_thr;

  assign thr_m1 = mode_act_i ? ACT_M1 : SLP_M1;
  assign differ = (sync_i != filt_q);
  assign at_thr = (cnt_q >= thr_m1);
  assign flip_o = differ && at_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (at_thr) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_i) != $past(filt_q))); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SLP_M1); // R3

endmodule

// File: rtl/swpw_runcnt.sv
module swpw_runcnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic hit_o
);

  localparam int unsigned W = swpw_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LIMIT_M1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == LIMIT_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en_i || hit_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_M1); // R7

endmodule

// File: rtl/swpw_ctrl.sv
module swpw_ctrl
  import swpw_pkg::*;
#(
  parameter int unsigned WAKE_CYC  = 6000,
  parameter int unsigned READY_CYC = 250000,
  parameter int unsigned WDOG_CYC  = 1000000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      filt_i,
  output pw_state_e state_o,
  output logic      stb_o,
  output logic      act_o
);

  pw_state_e st_q, st_d;
  logic      stb_q;
  logic      low_en, low_hit;
  logic      hi_en, hi_hit;
  logic      wd_en, wd_hit;

  assign low_en = (st_q == ST_SLEEP) && !filt_i;
  assign hi_en  = (st_q == ST_HOLD) && filt_i;
  assign wd_en  = (st_q != ST_SLEEP);

  swpw_runcnt #(.LIMIT(WAKE_CYC)) u_low_run (
    .clk(clk), .rst_n(rst_n), .en_i(low_en), .hit_o(low_hit));

  swpw_runcnt #(.LIMIT(READY_CYC)) u_ready (
    .clk(clk), .rst_n(rst_n), .en_i(hi_en), .hit_o(hi_hit));

  swpw_runcnt #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en_i(wd_en), .hit_o(wd_hit));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SLEEP: if (low_hit) st_d = ST_HOLD;
      ST_HOLD:  if (wd_hit) st_d = ST_SLEEP;
                else if (hi_hit) st_d = ST_IO;
      ST_IO:    if (wd_hit) st_d = ST_SLEEP;
      default:  st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SLEEP;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      stb_q <= (st_q == ST_SLEEP) && (st_d == ST_HOLD);
    end
  end

  assign state_o = st_q;
  assign stb_o   = stb_q;
  assign act_o   = (st_q != ST_SLEEP);

  AST_STB_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (st_q == ST_HOLD && $past(st_q) == ST_SLEEP)); // R5
  AST_EXIT_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SLEEP && $past(st_q) == ST_SLEEP) |-> stb_q); // R5
  AST_NO_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_SLEEP) |-> (st_q != ST_IO)); // R6
  AST_IO_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IO && $past(st_q) == ST_HOLD) |-> $past(filt_i)); // R6
  AST_WDOG_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> (st_q == ST_SLEEP)); // R7
  AST_IO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_IO && !$past(wd_hit)) |-> (st_q == ST_IO)); // R8
  AST_STATE_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'b11); // R9

endmodule

// File: rtl/swpw_top.sv
module swpw_top #(
  parameter longint unsigned CLK_HZ          = 100_000_000,
  parameter longint unsigned ACT_GLITCH_NS   = 45,
  parameter longint unsigned SLEEP_GLITCH_NS = 15_000,
  parameter longint unsigned WAKE_LOW_NS     = 60_000,
  parameter longint unsigned READY_NS        = 2_500_000,
  parameter longint unsigned WDOG_NS         = 1_300_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [1:0] state_o,
  output logic       line_filt_o,
  output logic       wake_stb_o
);

  localparam int unsigned ACT_CYC   = swpw_pkg::ns_to_cycles(CLK_HZ, ACT_GLITCH_NS);
  localparam int unsigned SLP_CYC   = swpw_pkg::ns_to_cycles(CLK_HZ, SLEEP_GLITCH_NS);
  localparam int unsigned WAKE_CYC  = swpw_pkg::ns_to_cycles(CLK_HZ, WAKE_LOW_NS);
  localparam int unsigned READY_CYC = swpw_pkg::ns_to_cycles(CLK_HZ, READY_NS);
  localparam int unsigned WDOG_CYC  = swpw_pkg::ns_to_cycles(CLK_HZ, WDOG_NS);

  logic                line_sync;
  logic                line_filt;
  logic                filt_flip;
  logic                mode_act;
  swpw_pkg::pw_state_e st;
  logic                stb;

  swpw_sync #(.IDLE_LEVEL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(line_i), .sync_o(line_sync));

  swpw_glitch #(.ACT_CYC(ACT_CYC), .SLP_CYC(SLP_CYC)) u_glitch (
    .clk(clk), .rst_n(rst_n), .sync_i(line_sync), .mode_act_i(mode_act),
    .filt_o(line_filt), .flip_o(filt_flip));

  swpw_ctrl #(.WAKE_CYC(WAKE_CYC), .READY_CYC(READY_CYC), .WDOG_CYC(WDOG_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .filt_i(line_filt), .state_o(st), .stb_o(stb),
    .act_o(mode_act));

  assign state_o     = st;
  assign line_filt_o = line_filt;
  assign wake_stb_o  = stb;

  initial begin
    AST_THR_ORDER: assert (ACT_CYC < SLP_CYC && SLP_CYC < WAKE_CYC); // R4
  end

  AST_FLIP_MOVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    filt_flip |=> (line_filt_o != $past(line_filt_o))); // R3

endmodule

// File: tb/swpw_top_bench.sv
module swpw_top_bench;

  localparam int ACT   = 4;
  localparam int SLP   = 20;
  localparam int WAKE  = 60;
  localparam int READY = 100;
  localparam int WDOG  = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_i = 1'b1;
  logic [1:0] state_o;
  logic       line_filt_o;
  logic       wake_stb_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, stb_cnt = 0, stb_cyc = 0, rise_cyc = 0;
  int low_cyc = 0, high_cyc = 0, io_diff = 0, sleep_diff = 0;
  bit io_seen = 0, sleep_seen = 0, timed_out = 0;
  logic [1:0] prev_st = 2'b00;
  logic       prev_filt = 1'b1;

  always #5 clk = ~clk;

  swpw_top #(
    .CLK_HZ(100_000_000), .ACT_GLITCH_NS(ACT*10), .SLEEP_GLITCH_NS(SLP*10),
    .WAKE_LOW_NS(WAKE*10), .READY_NS(READY*10), .WDOG_NS(WDOG*10)
  ) u_swpw_top (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .state_o(state_o),
    .line_filt_o(line_filt_o), .wake_stb_o(wake_stb_o));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (wake_stb_o) begin stb_cnt = stb_cnt + 1; stb_cyc = cyc; end
    if (!line_filt_o) low_cyc = low_cyc + 1;
    else high_cyc = high_cyc + 1;
    if (line_filt_o && !prev_filt && state_o == 2'b01) rise_cyc = cyc;
    if (state_o == 2'b10 && prev_st == 2'b01) begin io_seen = 1; io_diff = cyc - rise_cyc; end
    if (state_o == 2'b00 && prev_st != 2'b00) begin sleep_seen = 1; sleep_diff = cyc - stb_cyc; end
    prev_st = state_o;
    prev_filt = line_filt_o;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    stb_cnt = 0; low_cyc = 0; high_cyc = 0; io_seen = 0; sleep_seen = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_i = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(2);
    clear_mon();
  endtask

  task automatic low_pulse(int w);
    line_i = 1'b0; step(w); line_i = 1'b1;
  endtask

  task automatic wait_state(bit want_io);
    for (int i = 0; i < 3000; i++) begin
      if (want_io ? io_seen : sleep_seen) break;
      step(1);
    end
  endtask

  task automatic main_seq();
    // R1: reset values
    do_reset();
    chk(state_o == 2'b00, "R1", "state after reset", state_o, 0);
    chk(line_filt_o == 1'b1, "R1", "filtered level after reset", line_filt_o, 1);
    chk(wake_stb_o == 1'b0, "R1", "strobe after reset", wake_stb_o, 0);

    // R2: sleep-mode low pulse sweep around SLP
    for (int w = 1; w <= SLP + 2; w++) begin
      low_cyc = 0;
      low_pulse(w);
      step(SLP + 10);
      chk(low_cyc == ((w >= SLP) ? w : 0), "R2", $sformatf("sleep low width %0d", w),
          low_cyc, (w >= SLP) ? w : 0);
    end
    chk(stb_cnt == 0 && state_o == 2'b00, "R4", "no wake from short pulses", stb_cnt, 0);

    // R4 / R5: wake threshold sweep
    for (int w = WAKE - 3; w <= WAKE + 2; w++) begin
      do_reset();
      low_pulse(w);
      step(SLP + 20);
      chk(stb_cnt == ((w >= WAKE) ? 1 : 0), "R5", $sformatf("strobes for low %0d", w),
          stb_cnt, (w >= WAKE) ? 1 : 0);
      chk((state_o == 2'b01) == (w >= WAKE), "R4", $sformatf("wake for low %0d", w),
          state_o, (w >= WAKE) ? 1 : 0);
    end

    // R4: high gap inside a low run
    do_reset();
    line_i = 1'b0; step(40); line_i = 1'b1; step(5); line_i = 1'b0; step(40); line_i = 1'b1;
    step(60);
    chk(stb_cnt == 1, "R4", "short high gap keeps low run", stb_cnt, 1);
    do_reset();
    line_i = 1'b0; step(40); line_i = 1'b1; step(25); line_i = 1'b0; step(40); line_i = 1'b1;
    step(60);
    chk(stb_cnt == 0 && state_o == 2'b00, "R4", "long high gap splits low run", stb_cnt, 0);

    // R6 / R3 / R8 / R7: full awake cycle
    do_reset();
    low_pulse(WAKE + 5);
    wait_state(1);
    chk(io_seen, "R6", "entered I/O", io_seen, 1);
    chk(io_diff == READY, "R6", "ready interval", io_diff, READY);
    for (int w = 1; w <= ACT + 2; w++) begin
      low_cyc = 0;
      low_pulse(w);
      step(ACT + 8);
      chk(low_cyc == ((w >= ACT) ? w : 0), "R3", $sformatf("active low width %0d", w),
          low_cyc, (w >= ACT) ? w : 0);
    end
    for (int w = 1; w <= ACT + 2; w++) begin
      line_i = 1'b0; step(10);
      high_cyc = 0;
      line_i = 1'b1; step(w); line_i = 1'b0;
      step(ACT + 8);
      chk(high_cyc == ((w >= ACT) ? w : 0), "R3", $sformatf("active high width %0d", w),
          high_cyc, (w >= ACT) ? w : 0);
      line_i = 1'b1; step(10);
    end
    for (int k = 0; k < 3; k++) begin low_pulse(ACT + 3); step(10); end
    low_pulse(WAKE + 10);
    step(10);
    chk(state_o == 2'b10, "R8", "state held in I/O", state_o, 2);
    chk(stb_cnt == 1, "R8", "no extra strobe in I/O", stb_cnt, 1);
    wait_state(0);
    chk(sleep_seen && sleep_diff == WDOG, "R7", "watchdog from I/O", sleep_diff, WDOG);

    // R6: glitch does not restart, accepted low does
    do_reset();
    low_pulse(WAKE + 5);
    step(50);
    low_pulse(ACT - 2);
    wait_state(1);
    chk(io_seen && io_diff == READY, "R6", "glitch keeps ready timer", io_diff, READY);
    do_reset();
    low_pulse(WAKE + 5);
    step(50);
    low_pulse(ACT + 6);
    wait_state(1);
    chk(io_seen && io_diff == READY, "R6", "low restarts ready timer", io_diff, READY);

    // R7: stuck-low line, watchdog from hold state
    do_reset();
    line_i = 1'b0;
    wait_state(0);
    chk(sleep_seen && sleep_diff == WDOG, "R7", "watchdog from hold", sleep_diff, WDOG);
    chk(!io_seen, "R6", "no I/O while line low", io_seen, 0);
    line_i = 1'b1;
    step(40);
  endtask

  initial begin
    fork
      main_seq();
      begin step(150000); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "WDOG", "bench timeout", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule